// File: doc/BRIEF.md
# Blob Bounding-Box Feature Store

This block keeps a bounding box for every blob label that a connected-component labeler produces. Each entry holds four coordinates: the smallest and largest x, and the smallest and largest y. The labeler sends one command per pixel event. A command carries a 2-bit opcode, a primary label, a secondary (merger) label and the current pixel coordinate. The block reads the primary entry on one memory port and the secondary entry on the other port in the same cycle. In the next cycle it writes back the combined result.

Every accepted command runs through a fixed two-cycle sequence. In the capture cycle the block reads both entries and prepares the new entry. In the write cycle that entry is committed to storage. A finish command does not write anything. It latches the primary entry and presents it on a result port that uses a valid/ready handshake. A downstream stage, such as marker pattern matching, consumes the box from that port. A label that has been finished can be reused without clearing, because a new-blob command overwrites all four fields.

Top module: `blob_box_store`

## Requirements
- R1: After reset is released, `busy_o` and `res_valid_o` are both 0.
- R2: Opcode 2'b00 (new blob) sets xmin and xmax of the primary label to `cmd_x_i`, and ymin and ymax to `cmd_y_i`.
- R3: Opcode 2'b01 (update) lowers xmin and ymin to the command coordinate when it is smaller, and raises xmax and ymax when it is larger. A coordinate already inside the box leaves the entry unchanged.
- R4: Opcode 2'b10 (merge) writes, at the primary label, the field-wise minimum of both entries for xmin and ymin and the maximum for xmax and ymax. The entry at the merger label is left unchanged.
- R5: Opcode 2'b11 (finish) raises `res_valid_o` in the cycle after acceptance. The result carries the primary label and its stored box. The stored entry is not modified.
- R6: While `res_valid_o` is 1 and `res_ready_i` is 0, the result port holds all its values, and `busy_o` stays 1.
- R7: A command is accepted only on a clock edge where `cmd_valid_i` is 1 and `busy_o` is 0. `busy_o` is 1 in the cycle after acceptance. A command presented while `busy_o` is 1 has no effect.
- R8: Opcode 2'b00 on a label that was used before replaces all four of its fields.
- R9: Each non-finish command writes storage in exactly one cycle. That cycle is the second cycle of its sequence, so the following command reads the updated entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present |
| cmd_op_i | input | 2 | Opcode: 00 new, 01 update, 10 merge, 11 finish |
| cmd_label_i | input | LABEL_W | Primary label (port A address, merge target) |
| cmd_merge_i | input | LABEL_W | Merger label (port B address) |
| cmd_x_i | input | X_W | Pixel x coordinate |
| cmd_y_i | input | Y_W | Pixel y coordinate |
| busy_o | output | 1 | Command not accepted this cycle |
| res_valid_o | output | 1 | Finished box available |
| res_ready_i | input | 1 | Consumer takes the result |
| res_label_o | output | LABEL_W | Label of the finished blob |
| res_xmin_o | output | X_W | Finished box xmin |
| res_ymin_o | output | Y_W | Finished box ymin |
| res_xmax_o | output | X_W | Finished box xmax |
| res_ymax_o | output | Y_W | Finished box ymax |

## Verification
The bench sends merges in both directions:
- a primary entry that holds the smaller minimum;
- a primary entry that holds the larger maximum.

A design that always copies one port, or that compares fields in the wrong order, returns a box that is too small. The bench merges boxes that sit at the frame corners 0 and 639×479, which exposes truncated widths. It also reuses a finished label, which catches a new-blob command that only widens the old box. A finish is followed by a merge target readback, which would show a stray write. A command offered while the result is stalled must leave the store untouched. A result that drifts or drops while stalled is also caught.

// File: rtl/blob_box_pkg.sv
package blob_box_pkg;
  typedef enum logic [1:0] {
    OP_NEW = 2'b00,
    OP_UPD = 2'b01,
    OP_MRG = 2'b10,
    OP_FIN = 2'b11
  } box_op_e;

  typedef enum logic {
    ST_CAPTURE = 1'b0,
    ST_WRITE   = 1'b1
  } box_state_e;

  // field index order inside a stored word, MSB first
  localparam int FLD_XMIN = 0;
  localparam int FLD_YMIN = 1;
  localparam int FLD_XMAX = 2;
  localparam int FLD_YMAX = 3;
endpackage

// File: rtl/bbox_mem.sv
module bbox_mem #(
  parameter int LABEL_W = 8,
  parameter int WORD_W  = 38,
  localparam int DEPTH  = 1 << LABEL_W
) (
  input  logic               clk_i,
  input  logic [LABEL_W-1:0] addr_a_i,
  input  logic [LABEL_W-1:0] addr_b_i,
  output logic [WORD_W-1:0]  rd_a_o,
  output logic [WORD_W-1:0]  rd_b_o,
  input  logic               we_i,
  input  logic [LABEL_W-1:0] waddr_i,
  input  logic [WORD_W-1:0]  wdata_i
);
  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rd_a_o = mem_q[addr_a_i];
  assign rd_b_o = mem_q[addr_b_i];
endmodule

// File: rtl/bbox_field.sv
module bbox_field
  import blob_box_pkg::*;
#(
  parameter int W      = 10,
  parameter bit IS_MIN = 1'b1
) (
  input  box_op_e      op_i,
  input  logic [W-1:0] coord_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] f_o
);
  logic coord_lt_a, b_lt_a;

  assign coord_lt_a = coord_i < a_i;
  assign b_lt_a     = b_i < a_i;

  always_comb begin
    unique case (op_i)
      OP_NEW: f_o = coord_i;
      OP_UPD: begin
        if (IS_MIN) f_o = coord_lt_a ? coord_i : a_i;
        else        f_o = (coord_i > a_i) ? coord_i : a_i;
      end
      OP_MRG: begin
        if (IS_MIN) f_o = b_lt_a ? b_i : a_i;
        else        f_o = b_lt_a ? a_i : b_i;
      end
      default: f_o = a_i;
    endcase
  end
endmodule

// File: rtl/bbox_calc.sv
module bbox_calc
  import blob_box_pkg::*;
#(
  parameter int X_W = 10,
  parameter int Y_W = 9,
  localparam int WORD_W = 2*X_W + 2*Y_W
) (
  input  box_op_e           op_i,
  input  logic [X_W-1:0]    x_i,
  input  logic [Y_W-1:0]    y_i,
  input  logic [WORD_W-1:0] box_a_i,
  input  logic [WORD_W-1:0] box_b_i,
  output logic [WORD_W-1:0] box_w_o
);
  for (genvar g = 0; g < 4; g++) begin : g_fld
    localparam bit IS_X   = (g == FLD_XMIN) || (g == FLD_XMAX);
    localparam int W      = IS_X ? X_W : Y_W;
    localparam int LSB    = (g == FLD_XMIN) ? X_W + 2*Y_W :
                            (g == FLD_YMIN) ? X_W + Y_W :
                            (g == FLD_XMAX) ? Y_W : 0;
    localparam bit IS_MIN = (g == FLD_XMIN) || (g == FLD_YMIN);

    logic [W-1:0] coord;
    if (IS_X) begin : g_x
      assign coord = x_i;
    end else begin : g_y
      assign coord = y_i;
    end

    bbox_field #(.W(W), .IS_MIN(IS_MIN)) u_field (
      .op_i   (op_i),
      .coord_i(coord),
      .a_i    (box_a_i[LSB +: W]),
      .b_i    (box_b_i[LSB +: W]),
      .f_o    (box_w_o[LSB +: W])
    );
  end
endmodule

// File: rtl/bbox_ctrl.sv
module bbox_ctrl
  import blob_box_pkg::*;
#(
  parameter int LABEL_W = 8,
  parameter int WORD_W  = 38
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_valid_i,
  input  box_op_e            cmd_op_i,
  input  logic [LABEL_W-1:0] cmd_label_i,
  input  logic [WORD_W-1:0]  box_a_i,
  input  logic [WORD_W-1:0]  box_w_i,
  output logic               busy_o,
  output logic               we_o,
  output logic [LABEL_W-1:0] waddr_o,
  output logic [WORD_W-1:0]  wdata_o,
  output logic               res_valid_o,
  input  logic               res_ready_i,
  output logic [LABEL_W-1:0] res_label_o,
  output logic [WORD_W-1:0]  res_box_o
);
  box_state_e state_q;
  logic accept;

  assign busy_o = (state_q == ST_WRITE) || res_valid_o;
  assign accept = cmd_valid_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_CAPTURE;
      we_o        <= 1'b0;
      waddr_o     <= '0;
      wdata_o     <= '0;
      res_valid_o <= 1'b0;
      res_label_o <= '0;
      res_box_o   <= '0;
    end else begin
      if (accept) begin
        state_q <= ST_WRITE;
        we_o    <= (cmd_op_i != OP_FIN);
        waddr_o <= cmd_label_i;
        wdata_o <= box_w_i;
        if (cmd_op_i == OP_FIN) begin
          res_valid_o <= 1'b1;
          res_label_o <= cmd_label_i;
          res_box_o   <= box_a_i;
        end
      end else if (state_q == ST_WRITE) begin
        state_q <= ST_CAPTURE;
        we_o    <= 1'b0;
      end
      if (res_valid_o && res_ready_i) res_valid_o <= 1'b0;
    end
  end

  p_busy_after_accept_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !busy_o) |=> busy_o);

  p_res_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_ready_i) |=>
      (res_valid_o && busy_o && $stable(res_box_o) && $stable(res_label_o)));

  p_single_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |=> !we_o);

  p_finish_no_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(res_valid_o) |-> !we_o);

  p_write_in_second_cycle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> state_q == ST_WRITE);
endmodule

// File: rtl/blob_box_store.sv
module blob_box_store
  import blob_box_pkg::*;
#(
  parameter int LABEL_W = 8,
  parameter int X_W     = 10,
  parameter int Y_W     = 9,
  localparam int WORD_W = 2*X_W + 2*Y_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_valid_i,
  input  logic [1:0]         cmd_op_i,
  input  logic [LABEL_W-1:0] cmd_label_i,
  input  logic [LABEL_W-1:0] cmd_merge_i,
  input  logic [X_W-1:0]     cmd_x_i,
  input  logic [Y_W-1:0]     cmd_y_i,
  output logic               busy_o,
  output logic               res_valid_o,
  input  logic               res_ready_i,
  output logic [LABEL_W-1:0] res_label_o,
  output logic [X_W-1:0]     res_xmin_o,
  output logic [Y_W-1:0]     res_ymin_o,
  output logic [X_W-1:0]     res_xmax_o,
  output logic [Y_W-1:0]     res_ymax_o
);
  box_op_e           op;
  logic [WORD_W-1:0] box_a, box_b, box_w, wdata, res_box;
  logic [LABEL_W-1:0] waddr;
  logic              we;

  assign op = box_op_e'(cmd_op_i);

  bbox_mem #(.LABEL_W(LABEL_W), .WORD_W(WORD_W)) u_mem (
    .clk_i   (clk_i),
    .addr_a_i(cmd_label_i),
    .addr_b_i(cmd_merge_i),
    .rd_a_o  (box_a),
    .rd_b_o  (box_b),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (wdata)
  );

  bbox_calc #(.X_W(X_W), .Y_W(Y_W)) u_calc (
    .op_i   (op),
    .x_i    (cmd_x_i),
    .y_i    (cmd_y_i),
    .box_a_i(box_a),
    .box_b_i(box_b),
    .box_w_o(box_w)
  );

  bbox_ctrl #(.LABEL_W(LABEL_W), .WORD_W(WORD_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_valid_i(cmd_valid_i),
    .cmd_op_i   (op),
    .cmd_label_i(cmd_label_i),
    .box_a_i    (box_a),
    .box_w_i    (box_w),
    .busy_o     (busy_o),
    .we_o       (we),
    .waddr_o    (waddr),
    .wdata_o    (wdata),
    .res_valid_o(res_valid_o),
    .res_ready_i(res_ready_i),
    .res_label_o(res_label_o),
    .res_box_o  (res_box)
  );

  assign res_xmin_o = res_box[X_W+2*Y_W +: X_W];
  assign res_ymin_o = res_box[X_W+Y_W   +: Y_W];
  assign res_xmax_o = res_box[Y_W       +: X_W];
  assign res_ymax_o = res_box[0         +: Y_W];

  p_reset_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!busy_o && !res_valid_o));

  p_result_ordered_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(res_valid_o) |-> $past(cmd_valid_i && cmd_op_i == 2'b11));
endmodule

// File: tb/blob_box_store_tb.sv
`timescale 1ns/1ps
module blob_box_store_tb;
  localparam int LW = 8, XW = 10, YW = 9;
  localparam int VW = 2 + 2*LW + XW + YW + 1 + 2*XW + 2*YW;
  localparam int NV = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, res_ready = 1'b0;
  logic [1:0] cmd_op = '0;
  logic [LW-1:0] cmd_label = '0, cmd_merge = '0;
  logic [XW-1:0] cmd_x = '0;
  logic [YW-1:0] cmd_y = '0;
  logic busy, res_valid;
  logic [LW-1:0] res_label;
  logic [XW-1:0] res_xmin, res_xmax;
  logic [YW-1:0] res_ymin, res_ymax;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  blob_box_store #(.LABEL_W(LW), .X_W(XW), .Y_W(YW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_label_i(cmd_label), .cmd_merge_i(cmd_merge), .cmd_x_i(cmd_x),
    .cmd_y_i(cmd_y), .busy_o(busy), .res_valid_o(res_valid),
    .res_ready_i(res_ready), .res_label_o(res_label), .res_xmin_o(res_xmin),
    .res_ymin_o(res_ymin), .res_xmax_o(res_xmax), .res_ymax_o(res_ymax));

  function automatic logic [VW-1:0] mk(int op, int lab, int mrg, int x, int y,
                                       int e, int a, int b, int c, int d);
    return {op[1:0], lab[LW-1:0], mrg[LW-1:0], x[XW-1:0], y[YW-1:0], e[0],
            a[XW-1:0], b[YW-1:0], c[XW-1:0], d[YW-1:0]};
  endfunction

  // op label merge x y | expect_result xmin ymin xmax ymax
  localparam logic [VW-1:0] VEC [NV] = '{
    mk(0, 3, 0, 100, 50,  0, 0, 0, 0, 0),       // R2 new
    mk(1, 3, 0, 120, 40,  0, 0, 0, 0, 0),       // R3 grow xmax, ymin
    mk(1, 3, 0, 90,  60,  0, 0, 0, 0, 0),       // R3 grow xmin, ymax
    mk(1, 3, 0, 95,  55,  0, 0, 0, 0, 0),       // R3 inside, no change
    mk(3, 3, 0, 0,   0,   1, 90, 40, 120, 60),  // R3 R5 R9
    mk(0, 5, 0, 300, 200, 0, 0, 0, 0, 0),
    mk(1, 5, 0, 310, 210, 0, 0, 0, 0, 0),
    mk(2, 3, 5, 0,   0,   0, 0, 0, 0, 0),       // R4 merge 5 into 3
    mk(3, 3, 0, 0,   0,   1, 90, 40, 310, 210), // R4
    mk(3, 5, 0, 0,   0,   1, 300, 200, 310, 210), // R4 R5 source untouched
    mk(0, 3, 0, 7,   8,   0, 0, 0, 0, 0),       // R8 reuse
    mk(3, 3, 0, 0,   0,   1, 7, 8, 7, 8),       // R8
    mk(0, 0, 0, 0,   0,   0, 0, 0, 0, 0),
    mk(0, 255, 0, 639, 479, 0, 0, 0, 0, 0),
    mk(2, 255, 0, 0, 0,   0, 0, 0, 0, 0),       // R4 corners
    mk(3, 255, 0, 0, 0,   1, 0, 0, 639, 479)    // R4 R2 extremes
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(int op, int lab, int mrg, int x, int y);
    @(negedge clk);
    while (busy) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op[1:0]; cmd_label = lab[LW-1:0];
    cmd_merge = mrg[LW-1:0]; cmd_x = x[XW-1:0]; cmd_y = y[YW-1:0];
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  task automatic take();
    @(negedge clk);
    res_ready = 1'b1;
    @(posedge clk); #1;
    res_ready = 1'b0;
  endtask

  task automatic chk_box(string tag, int lab, int a, int b, int c, int d);
    chk({tag, " valid"}, 32'(res_valid), 1);
    chk({tag, " label"}, 32'(res_label), lab);
    chk({tag, " xmin"}, 32'(res_xmin), a);
    chk({tag, " ymin"}, 32'(res_ymin), b);
    chk({tag, " xmax"}, 32'(res_xmax), c);
    chk({tag, " ymax"}, 32'(res_ymax), d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 res_valid", 32'(res_valid), 0);

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      send(int'(v[VW-1 -: 2]), int'(v[VW-3 -: LW]), int'(v[VW-3-LW -: LW]),
           int'(v[VW-3-2*LW -: XW]), int'(v[VW-3-2*LW-XW -: YW]));
      chk($sformatf("R7 busy after accept v%0d", i), 32'(busy), 1);
      if (v[2*XW+2*YW]) begin
        chk_box($sformatf("R5 v%0d", i), int'(v[VW-3 -: LW]),
                int'(v[XW+2*YW +: XW]), int'(v[XW+YW +: YW]),
                int'(v[YW +: XW]), int'(v[0 +: YW]));
        take();
        chk($sformatf("R5 released v%0d", i), 32'(res_valid), 0);
      end else begin
        @(posedge clk); #1;
        chk($sformatf("R9 idle after write v%0d", i), 32'(busy), 0);
      end
    end

    // R6 stall with R7 ignored command while busy
    send(3, 5, 0, 0, 0);
    repeat (4) begin
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 2'b00; cmd_label = 8'd5; cmd_x = 10'd1; cmd_y = 9'd1;
      @(posedge clk); #1;
      chk_box("R6 held", 5, 300, 200, 310, 210);
      chk("R6 busy while pending", 32'(busy), 1);
    end
    cmd_valid = 1'b0;
    take();
    send(3, 5, 0, 0, 0);
    chk_box("R7 ignored cmd no effect", 5, 300, 200, 310, 210);
    take();

    // R9 back-to-back: update then finish reads the fresh entry
    send(0, 9, 0, 50, 50);
    send(1, 9, 0, 60, 40);
    send(3, 9, 0, 0, 0);
    chk_box("R9 fresh read", 9, 50, 40, 60, 50);
    take();

    // R1 reset mid-result clears outputs
    send(3, 9, 0, 0, 0);
    #1 rst_n = 1'b0;
    #1 chk("R1 reset clears valid", 32'(res_valid), 0);
    chk("R1 reset clears busy", 32'(busy), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule